// File: doc/BRIEF.md
# Temperature limit alert logic

This block watches two temperature channels, channel 0 (internal sensor) and channel 1 (external sensor). Each time a new pair of readings arrives it compares every reading against a high limit and a low limit for its channel. A limit is only treated as broken after a programmable number of back-to-back out-of-limit readings. A limit that is broken for long enough sets a flag in a high-limit status register or a low-limit status register. Any set flag pulls the active-low alert output low and shows as a summary bit in a main status register.

A simple register port is used to program the limits and the consecutive-count field, and to read the status. Reading a limit status register clears it in latched mode. The `cmp_mode` input switches the flags to comparator behaviour. In that mode each flag follows the filtered condition at every measurement and is not cleared by reads. Temperatures and limits are unsigned codes.

Top module: `temp_limit_alert`

## Requirements
- R1: After reset the channel high limits read 55h, the low limits read 00h and the count register at 20h reads 70h: bits 6:4 hold the shutdown count at 111 and bits 2:0 hold the alert count at 000. Both status registers read 00h and `alert_n` is 1.
- R2: A reading is out of its high limit when it is strictly greater than that limit, and out of its low limit when it is strictly smaller than that limit. A reading equal to a limit is in limit.
- R3: Alert count bits 2:0 use thermometer codes: 000 needs 1 consecutive out-of-limit reading, 001 needs 2, 011 needs 3 and 111 needs 4.
- R4: A code that is not a thermometer code needs one more reading than the number of ones counted upward from bit 0 before the first zero. For example 101 needs 2 and 110 needs 1.
- R5: Any in-limit reading restarts the consecutive count of that channel and limit.
- R6: The high-limit status register is at 35h and the low-limit status register is at 36h. In both, bit 0 is channel 0, bit 1 is channel 1, and bits 7:2 read 0.
- R7: The main status register is at 02h. Bit 4 is 1 while any high-limit flag is set, bit 3 is 1 while any low-limit flag is set, and every other bit reads 0.
- R8: In latched mode (`cmp_mode`=0) a flag stays set until its status register is read. A read returns the current value and clears the whole register, and with it the matching summary bit, from the next cycle on.
- R9: If a read of a status register and a new qualifying reading for one of its flags fall in the same cycle, that flag ends up set.
- R10: In comparator mode (`cmp_mode`=1) each flag takes the filtered result of every measurement, so it clears at the first reading back in limit, and reads do not clear it.
- R11: `alert_n` is 0 exactly while at least one limit flag is set.
- R12: The limits are writable at 05h (channel 0 high), 06h (channel 0 low), 07h (channel 1 high) and 08h (channel 1 low). The count register at 20h keeps only bits 6:4 and 2:0. Writes to the status registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_valid | input | 1 | A new reading for every channel is present this cycle |
| meas_data | input | 2x8 | Readings, channel 0 in the low byte |
| cmp_mode | input | 1 | 0 latched flags, 1 comparator flags |
| reg_rd | input | 1 | Register read strobe (fires the read-to-clear) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alert_n | output | 1 | Active-low alert |

## Verification
A wrong run counter shows at the ports as a flag and `alert_n` edge that arrives one measurement early or late. It can also show as a flag set after a run broken by an in-limit reading. Either shows on the clock after the measurement concerned. A flag that is held or cleared wrongly shows as a wrong value in the next read of 35h, 36h or 02h, and as `alert_n` disagreeing with those registers on that same cycle. The bench compares read data and `alert_n` against its model on every clock, so a divergence is reported within one cycle of its cause.

// File: rtl/tla_pkg.sv
// Shared constants and the count-code decoder for the temperature limit alert.
// Assumes 8-bit register data and address.
package tla_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int RUN_W    = 3;
    localparam int RUN_MAX  = 4;

    localparam logic [ADDR_W-1:0] A_MAIN     = 8'h02;
    localparam logic [ADDR_W-1:0] A_LIM_BASE = 8'h05;
    localparam logic [ADDR_W-1:0] A_CFG      = 8'h20;
    localparam logic [ADDR_W-1:0] A_HSTAT    = 8'h35;
    localparam logic [ADDR_W-1:0] A_LSTAT    = 8'h36;

    localparam int MAIN_HIGH_BIT = 4;
    localparam int MAIN_LOW_BIT  = 3;

    localparam logic [DATA_W-1:0] CFG_RST  = 8'h70;
    localparam logic [DATA_W-1:0] CFG_MASK = 8'h77;

    // Required run length: one plus the ones counted upward from bit 0.
    function automatic logic [RUN_W-1:0] run_need(input logic [2:0] code);
        if (!code[0])      return 3'd1;
        else if (!code[1]) return 3'd2;
        else if (!code[2]) return 3'd3;
        else               return 3'd4;
    endfunction
endpackage

// File: rtl/tla_regs.sv
// Programmable limit and count registers.
// Channel ch high limit at A_LIM_BASE+2*ch and low limit one above it.
// Assumes TEMP_W <= DATA_W.
module tla_regs #(
    parameter int TEMP_W = 8,
    parameter int NUM_CH = 2,
    parameter logic [TEMP_W-1:0] HI_RST = 8'h55,
    parameter logic [TEMP_W-1:0] LO_RST = 8'h00
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr,
    input  logic [tla_pkg::ADDR_W-1:0]        addr,
    input  logic [tla_pkg::DATA_W-1:0]        wdata,
    output logic [NUM_CH-1:0][TEMP_W-1:0]     hi_lim,
    output logic [NUM_CH-1:0][TEMP_W-1:0]     lo_lim,
    output logic [tla_pkg::DATA_W-1:0]        cfg
);
    import tla_pkg::*;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lim
        localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(int'(A_LIM_BASE) + 2*ch);
        localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(int'(A_LIM_BASE) + 2*ch + 1);

        // Limit storage for one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_lim[ch] <= HI_RST;
                lo_lim[ch] <= LO_RST;
            end else if (wr) begin
                if (addr == A_HI) hi_lim[ch] <= wdata[TEMP_W-1:0];
                if (addr == A_LO) lo_lim[ch] <= wdata[TEMP_W-1:0];
            end
        end
    end

    // Count register; unused bits never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cfg <= CFG_RST;
        else if (wr && addr == A_CFG) cfg <= wdata & CFG_MASK;
    end

    assert_cfg_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg & ~CFG_MASK) == '0);
endmodule

// File: rtl/tla_filter.sv
// Consecutive out-of-limit run counter for one channel/limit pair.
// Saturates at RUN_MAX, restarts on an in-limit sample.
// qual is valid in the sample cycle only.
module tla_filter #(
    parameter int RUN_MAX = tla_pkg::RUN_MAX,
    localparam int RUN_W  = tla_pkg::RUN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             out_lim,
    input  logic [RUN_W-1:0] need,
    output logic             qual
);
    logic [RUN_W-1:0] run_q, run_d;

    // Next run length for the current sample.
    always_comb begin
        if (!out_lim)                       run_d = '0;
        else if (run_q >= RUN_W'(RUN_MAX))  run_d = RUN_W'(RUN_MAX);
        else                                run_d = run_q + 1'b1;
    end

    assign qual = sample && out_lim && (run_d >= need);

    // Run counter advances only on samples.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (sample) run_q <= run_d;
    end

    assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(RUN_MAX));
    assert_run_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !out_lim) |=> (run_q == '0));
endmodule

// File: rtl/tla_flag.sv
// One limit status flag, latched or comparator behaviour.
// A set beats a read-clear in the same cycle.
module tla_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic qual,
    input  logic rd_clr,
    input  logic cmp_mode,
    output logic flag
);
    // Flag update by mode.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag <= 1'b0;
        else if (cmp_mode) begin
            if (sample)          flag <= qual;
        end else if (sample && qual) flag <= 1'b1;
        else if (rd_clr)         flag <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_mode && sample && qual) |=> flag);
    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_mode && !sample && !rd_clr) |=> $stable(flag));
    assert_cmp_no_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode && !sample) |=> $stable(flag));
endmodule

// File: rtl/temp_limit_alert.sv
// Temperature limit alert: per-channel high/low compare, run filter,
// read-to-clear status flags, main status summary and active-low alert.
// Assumes NUM_CH <= 8 and TEMP_W <= 8. Compares are unsigned.
module temp_limit_alert #(
    parameter int TEMP_W = 8,
    parameter int NUM_CH = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          meas_valid,
    input  logic [NUM_CH-1:0][TEMP_W-1:0] meas_data,
    input  logic                          cmp_mode,
    input  logic                          reg_rd,
    input  logic                          reg_wr,
    input  logic [7:0]                    reg_addr,
    input  logic [7:0]                    reg_wdata,
    output logic [7:0]                    reg_rdata,
    output logic                          alert_n
);
    import tla_pkg::*;

    logic [NUM_CH-1:0][TEMP_W-1:0] hi_lim, lo_lim;
    logic [DATA_W-1:0]             cfg;
    logic [RUN_W-1:0]              need;
    logic [NUM_CH-1:0]             out_hi, out_lo, qual_hi, qual_lo;
    logic [NUM_CH-1:0]             hi_stat, lo_stat;
    logic                          clr_hi, clr_lo;

    tla_regs #(.TEMP_W(TEMP_W), .NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .hi_lim(hi_lim), .lo_lim(lo_lim), .cfg(cfg));

    assign need   = run_need(cfg[2:0]);
    assign clr_hi = reg_rd && (reg_addr == A_HSTAT);
    assign clr_lo = reg_rd && (reg_addr == A_LSTAT);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign out_hi[ch] = meas_data[ch] > hi_lim[ch];
        assign out_lo[ch] = meas_data[ch] < lo_lim[ch];

        tla_filter u_hi_run (.clk(clk), .rst_n(rst_n), .sample(meas_valid),
            .out_lim(out_hi[ch]), .need(need), .qual(qual_hi[ch]));
        tla_filter u_lo_run (.clk(clk), .rst_n(rst_n), .sample(meas_valid),
            .out_lim(out_lo[ch]), .need(need), .qual(qual_lo[ch]));

        tla_flag u_hi_flag (.clk(clk), .rst_n(rst_n), .sample(meas_valid),
            .qual(qual_hi[ch]), .rd_clr(clr_hi), .cmp_mode(cmp_mode),
            .flag(hi_stat[ch]));
        tla_flag u_lo_flag (.clk(clk), .rst_n(rst_n), .sample(meas_valid),
            .qual(qual_lo[ch]), .rd_clr(clr_lo), .cmp_mode(cmp_mode),
            .flag(lo_stat[ch]));
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_MAIN) begin
            reg_rdata[MAIN_HIGH_BIT] = |hi_stat;
            reg_rdata[MAIN_LOW_BIT]  = |lo_stat;
        end else if (reg_addr == A_CFG) begin
            reg_rdata = cfg;
        end else if (reg_addr == A_HSTAT) begin
            reg_rdata[NUM_CH-1:0] = hi_stat;
        end else if (reg_addr == A_LSTAT) begin
            reg_rdata[NUM_CH-1:0] = lo_stat;
        end
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (reg_addr == 8'(int'(A_LIM_BASE) + 2*ch))     reg_rdata[TEMP_W-1:0] = hi_lim[ch];
            if (reg_addr == 8'(int'(A_LIM_BASE) + 2*ch + 1)) reg_rdata[TEMP_W-1:0] = lo_lim[ch];
        end
    end

    assign alert_n = ~(|hi_stat || |lo_stat);

    assert_hstat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hi && !cmp_mode && !meas_valid) |=> (hi_stat == '0));
    assert_lstat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lo && !cmp_mode && !meas_valid) |=> (lo_stat == '0));
    assert_alert_after_sample_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_n) |-> $past(meas_valid));
endmodule

// File: tb/temp_limit_alert_test.sv
`timescale 1ns/1ps
module temp_limit_alert_test;
    logic            clk = 0;
    logic            rst_n = 0;
    logic            meas_valid = 0;
    logic [1:0][7:0] meas_data = '0;
    logic            cmp_mode = 0;
    logic            reg_rd = 0, reg_wr = 0;
    logic [7:0]      reg_addr = 0, reg_wdata = 0;
    logic [7:0]      reg_rdata;
    logic            alert_n;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference model state
    int m_hi[2], m_lo[2], m_cfg, m_run_h[2], m_run_l[2];
    bit m_sh[2], m_sl[2];

    always #2 clk = ~clk;

    temp_limit_alert uut (.clk(clk), .rst_n(rst_n), .meas_valid(meas_valid),
        .meas_data(meas_data), .cmp_mode(cmp_mode), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alert_n(alert_n));

    function automatic int need_of(int code);
        int n = 1;
        for (int b = 0; b < 3; b++) begin
            if (((code >> b) & 1) == 0) break;
            n++;
        end
        return n;
    endfunction

    function automatic logic [7:0] model_rd(logic [7:0] a);
        case (a)
            8'h02: return {3'b0, (m_sh[0] | m_sh[1]), (m_sl[0] | m_sl[1]), 3'b0};
            8'h05: return 8'(m_hi[0]);
            8'h06: return 8'(m_lo[0]);
            8'h07: return 8'(m_hi[1]);
            8'h08: return 8'(m_lo[1]);
            8'h20: return 8'(m_cfg);
            8'h35: return {6'b0, m_sh[1], m_sh[0]};
            8'h36: return {6'b0, m_sl[1], m_sl[0]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_hi[c] = 'h55; m_lo[c] = 0; m_run_h[c] = 0; m_run_l[c] = 0;
            m_sh[c] = 0; m_sl[c] = 0;
        end
        m_cfg = 'h70;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int need = need_of(m_cfg & 7);
        for (int c = 0; c < 2; c++) begin
            int v = meas_data[c];
            bit oh = v > m_hi[c], ol = v < m_lo[c];
            bit qh, ql;
            if (meas_valid) begin
                m_run_h[c] = oh ? ((m_run_h[c] < 4) ? m_run_h[c] + 1 : 4) : 0;
                m_run_l[c] = ol ? ((m_run_l[c] < 4) ? m_run_l[c] + 1 : 4) : 0;
            end
            qh = meas_valid && oh && (m_run_h[c] >= need);
            ql = meas_valid && ol && (m_run_l[c] >= need);
            if (cmp_mode) begin
                if (meas_valid) begin m_sh[c] = qh; m_sl[c] = ql; end
            end else begin
                if (qh) m_sh[c] = 1; else if (reg_rd && reg_addr == 8'h35) m_sh[c] = 0;
                if (ql) m_sl[c] = 1; else if (reg_rd && reg_addr == 8'h36) m_sl[c] = 0;
            end
        end
        if (reg_wr) begin
            case (reg_addr)
                8'h05: m_hi[0] = reg_wdata;
                8'h06: m_lo[0] = reg_wdata;
                8'h07: m_hi[1] = reg_wdata;
                8'h08: m_lo[1] = reg_wdata;
                8'h20: m_cfg = reg_wdata & 8'h77;
                default: ;
            endcase
        end
    endtask

    // One clock: drive, compare outputs against the model, advance model.
    task automatic cyc(bit rd, bit wr, logic [7:0] a, logic [7:0] wd,
                       bit mv, logic [7:0] mi, logic [7:0] me, string tag);
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        meas_valid = mv; meas_data[0] = mi; meas_data[1] = me;
        #1;
        check(tag, "reg_rdata", reg_rdata, model_rd(a));
        check(tag, "alert_n", alert_n, !(m_sh[0] | m_sh[1] | m_sl[0] | m_sl[1]));
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, string tag);  cyc(1, 0, a, 0, 0, 0, 0, tag); endtask
    task automatic wr(logic [7:0] a, logic [7:0] d, string tag); cyc(0, 1, a, d, 0, 0, 0, tag); endtask
    task automatic ms(logic [7:0] i, logic [7:0] e, string tag); cyc(0, 0, 8'h02, 0, 1, i, e, tag); endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd(8'h05, "R1"); rd(8'h06, "R1"); rd(8'h07, "R1"); rd(8'h08, "R1");
        rd(8'h20, "R1"); rd(8'h35, "R1"); rd(8'h36, "R1"); rd(8'h02, "R1");
        // R12 writes, status write ignored, reserved cfg bits dropped
        wr(8'h05, 8'h40, "R12"); wr(8'h06, 8'h10, "R12");
        wr(8'h07, 8'h50, "R12"); wr(8'h08, 8'h20, "R12");
        wr(8'h35, 8'hFF, "R12"); wr(8'h36, 8'hFF, "R12"); wr(8'h20, 8'hF8, "R12");
        rd(8'h35, "R12"); rd(8'h36, "R12"); rd(8'h20, "R12"); rd(8'h07, "R12");
        wr(8'h20, 8'h70, "R3");
        // R2 equality is in limit, one above trips (count 1)
        ms(8'h40, 8'h20, "R2"); rd(8'h35, "R2"); rd(8'h36, "R2");
        ms(8'h41, 8'h30, "R2"); rd(8'h02, "R7"); rd(8'h35, "R6");
        rd(8'h02, "R8"); rd(8'h35, "R8");
        ms(8'h20, 8'h1F, "R2"); rd(8'h02, "R7"); rd(8'h36, "R6"); rd(8'h36, "R8");
        ms(8'h20, 8'h51, "R11"); rd(8'h35, "R11"); rd(8'h02, "R11");
        // R3 thermometer counts, R5 restart
        wr(8'h20, 8'h71, "R3");
        ms(8'h45, 8'h30, "R3"); rd(8'h35, "R3"); ms(8'h45, 8'h30, "R3"); rd(8'h35, "R3");
        ms(8'h45, 8'h30, "R5"); ms(8'h20, 8'h30, "R5"); ms(8'h45, 8'h30, "R5"); rd(8'h35, "R5");
        wr(8'h20, 8'h73, "R3");
        for (int k = 0; k < 4; k++) ms(8'h30, 8'h05, "R3");
        rd(8'h36, "R3"); rd(8'h36, "R3");
        wr(8'h20, 8'h77, "R3");
        for (int k = 0; k < 3; k++) ms(8'h30, 8'h60, "R3");
        ms(8'h30, 8'h20, "R5");
        for (int k = 0; k < 5; k++) ms(8'h30, 8'h60, "R3");
        rd(8'h35, "R3"); rd(8'h35, "R3");
        // R4 non-thermometer codes
        wr(8'h20, 8'h05, "R4");
        ms(8'h50, 8'h30, "R4"); rd(8'h35, "R4"); ms(8'h50, 8'h30, "R4"); rd(8'h35, "R4");
        wr(8'h20, 8'h06, "R4");
        ms(8'h30, 8'h10, "R4"); rd(8'h36, "R4");
        // R9 set wins over read-clear in the same cycle
        wr(8'h20, 8'h00, "R9");
        cyc(1, 0, 8'h35, 0, 1, 8'h48, 8'h30, "R9"); rd(8'h35, "R9");
        cyc(1, 0, 8'h36, 0, 1, 8'h05, 8'h30, "R9"); rd(8'h36, "R9"); rd(8'h36, "R9");
        cyc(1, 0, 8'h35, 0, 1, 8'h30, 8'h58, "R9"); rd(8'h35, "R9");
        // R10 comparator mode
        cmp_mode = 1;
        ms(8'h30, 8'h30, "R10"); ms(8'h48, 8'h10, "R10");
        rd(8'h35, "R10"); rd(8'h35, "R10"); rd(8'h36, "R10"); rd(8'h02, "R10");
        ms(8'h48, 8'h30, "R10"); rd(8'h36, "R10"); rd(8'h35, "R10");
        ms(8'h30, 8'h30, "R10"); rd(8'h35, "R10"); rd(8'h02, "R11");
        wr(8'h20, 8'h01, "R10");
        ms(8'h48, 8'h30, "R10"); rd(8'h35, "R10"); ms(8'h48, 8'h30, "R10"); rd(8'h35, "R10");
        cmp_mode = 0;
        rd(8'h35, "R8"); rd(8'h35, "R8"); rd(8'h02, "R8");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule